// File: doc/BRIEF.md
# Filtered Channel Interrupt Combiner

This block collects the active-low interrupt lines of several downstream bus channels and merges them into one active-low, open-drain interrupt toward the bus master. Each line is first brought into the system clock domain. A small per-channel state machine then judges it, and it only accepts a change of level once the new level has held for a programmable number of clock cycles. A low level must hold for `LOW_HOLD` cycles before the channel counts as interrupting. A high level must hold for `HIGH_HOLD` cycles before the interrupt counts as gone. Glitches shorter than these windows are dropped.

The filtered levels drive a status vector with one bit per channel, which the control-register read path places in the upper nibble of its read byte. Detection runs whether or not a channel is currently switched onto the bus. The status bits are not latched: they follow the filtered input levels, so an interrupt clears as soon as its source lets go and the release window expires. The open-drain pin is modelled as a drive-low enable.

With the default 200 MHz clock, `LOW_HOLD = 200` is 1 µs and `HIGH_HOLD = 100` is 0.5 µs. The resulting assert latency is about 1.01 µs, inside the 4 µs budget. The release latency is about 0.51 µs, inside the 2 µs budget.

Per-channel filter states and transitions:

| State | Meaning |
|---|---|
| `FLT_QUIET` | filtered high, no interrupt |
| `FLT_FALLING` | qualifying a low level |
| `FLT_PENDING` | filtered low, interrupt pending |
| `FLT_RISING` | qualifying a high level while still pending |

| Transition | Condition |
|---|---|
| QUIET → FALLING | synchronized level is low |
| FALLING → QUIET | level returns high before the low window completes (low glitch dropped) |
| FALLING → PENDING | low seen on `LOW_HOLD` consecutive samples |
| PENDING → RISING | synchronized level is high |
| RISING → PENDING | level returns low before the high window completes (high glitch dropped) |
| RISING → QUIET | high seen on `HIGH_HOLD` consecutive samples |

Top module: `irqc_combiner`

## Requirements
- R1: While and right after reset, every channel is idle: `irq_status` reads all zeros and `irq_drive_low` is 0 (released).
- R2: `irq_drive_low` is 1 exactly when at least one bit of `irq_status` is 1. This is the AND of the active-low filtered inputs.
- R3: Bit i of `irq_status` belongs to input `irq_in_n[i]`. A value of 1 means channel i has an interrupt pending.
- R4: A low level on an input lasting fewer than `LOW_HOLD` clock cycles leaves that channel's status at 0. A low level lasting `LOW_HOLD` cycles or more sets it.
- R5: While a channel is pending, a high level lasting fewer than `HIGH_HOLD` cycles does not clear its status.
- R6: A status bit rises exactly `LOW_HOLD + SYNC_STAGES` rising clock edges after the input first goes low, provided the input stays low.
- R7: A status bit falls exactly `HIGH_HOLD + SYNC_STAGES` rising clock edges after the input returns high, provided the input stays high.
- R8: Status is not latched. Once the source returns high, the bit clears after the release window without any other action.
- R9: The channels are independent. Activity on one input never changes the status of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in_n | input | N_CH | Raw active-low interrupt lines, bit i = channel i |
| irq_status | output | N_CH | Filtered pending flags, 1 = channel interrupting |
| irq_drive_low | output | 1 | Open-drain pull-down enable for the merged interrupt pin |

## Verification
An input change made between clock edges first reaches the filter after `SYNC_STAGES` rising edges. From there the status moves exactly `LOW_HOLD` or `HIGH_HOLD` edges later, and the drive-low enable moves in the same cycle as the status because it is combinational on the filter states. The bench drives inputs on falling edges. On each falling edge it pushes the applied value through its own `SYNC_STAGES`-deep delay line into a run-length model of the requirements, and compares both outputs there, half a cycle after the edge that could have changed them. The directed latency checks count edges from the falling edge where the input changed and sample one edge before and exactly at the edge on which the change is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Per-channel filter state. The two qualifying states keep the last
    // accepted level while the opposite level is being timed.
    typedef enum logic [1:0] {
        FLT_QUIET   = 2'd0,
        FLT_FALLING = 2'd1,
        FLT_PENDING = 2'd2,
        FLT_RISING  = 2'd3
    } flt_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
// Multi-flop synchronizer for a vector of asynchronous active-low lines.
// Every stage resets to 1, which is the inactive level.
module irqc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '1;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irqc_filter.sv
// Pulse-width rejection filter for one active-low line. A new level is
// accepted only after it has been seen on a full window of consecutive
// samples. The low and high windows are separate. Both must be >= 2.
module irqc_filter
    import irqc_pkg::*;
#(
    parameter int LOW_HOLD  = 200,
    parameter int HIGH_HOLD = 100,
    parameter int CNT_W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,      // synchronized raw level, active low
    output logic pending     // filtered: 1 = interrupt asserted
);

    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_HOLD - 1);
    localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_HOLD - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic; cnt_q holds the number of samples already seen at
    // the level being qualified.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FLT_QUIET: begin
                if (!lvl_n) begin
                    state_d = FLT_FALLING;
                    cnt_d   = CNT_ONE;
                end
            end
            FLT_FALLING: begin
                if (lvl_n) begin
                    state_d = FLT_QUIET;      // low glitch dropped
                    cnt_d   = '0;
                end else if (cnt_q == LOW_LAST) begin
                    state_d = FLT_PENDING;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + CNT_ONE;
                end
            end
            FLT_PENDING: begin
                if (lvl_n) begin
                    state_d = FLT_RISING;
                    cnt_d   = CNT_ONE;
                end
            end
            FLT_RISING: begin
                if (!lvl_n) begin
                    state_d = FLT_PENDING;    // high glitch dropped
                    cnt_d   = '0;
                end else if (cnt_q == HIGH_LAST) begin
                    state_d = FLT_QUIET;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + CNT_ONE;
                end
            end
        endcase
    end

    // Output decode: the accepted level is low in both pending-side states
    always_comb begin
        unique case (state_q)
            FLT_QUIET,   FLT_FALLING: pending = 1'b0;
            FLT_PENDING, FLT_RISING:  pending = 1'b1;
        endcase
    end

endmodule

// File: rtl/irqc_combiner.sv
// Filtered interrupt combiner: synchronize, filter per channel, merge.
module irqc_combiner
    import irqc_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_HOLD    = 200,
    parameter int HIGH_HOLD   = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] irq_in_n,
    output logic [N_CH-1:0] irq_status,
    output logic            irq_drive_low
);

    localparam int CNT_W = $clog2(max_u(LOW_HOLD, HIGH_HOLD) + 1);

    logic [N_CH-1:0] sync_lvl;

    irqc_sync #(
        .WIDTH  (N_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in_n),
        .sync_out (sync_lvl)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        irqc_filter #(
            .LOW_HOLD  (LOW_HOLD),
            .HIGH_HOLD (HIGH_HOLD),
            .CNT_W     (CNT_W)
        ) u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_n   (sync_lvl[ch]),
            .pending (irq_status[ch])
        );
    end

    // Wired-AND of the active-low lines becomes an OR of pending flags
    assign irq_drive_low = |irq_status;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N_CH      = 4,
    parameter int LOW_HOLD  = 200,
    parameter int HIGH_HOLD = 100
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] sync_lvl,
    input logic [N_CH-1:0] irq_status,
    input logic            irq_drive_low
);

    localparam int CW = $clog2(((LOW_HOLD > HIGH_HOLD) ? LOW_HOLD : HIGH_HOLD) + 2);
    localparam logic [CW-1:0] LO_LIM = CW'(LOW_HOLD);
    localparam logic [CW-1:0] HI_LIM = CW'(HIGH_HOLD);

    // R2: merged pin follows the per-channel filters
    p_drive_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive_low == (irq_status != '0));

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        logic [CW-1:0] lo_run, hi_run;

        // Samples of a level that is waiting to be accepted, saturating
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_run <= '0;
                hi_run <= '0;
            end else begin
                if (!sync_lvl[g] && !irq_status[g]) begin
                    if (lo_run <= LO_LIM) lo_run <= lo_run + 1'b1;
                end else begin
                    lo_run <= '0;
                end
                if (sync_lvl[g] && irq_status[g]) begin
                    if (hi_run <= HI_LIM) hi_run <= hi_run + 1'b1;
                end else begin
                    hi_run <= '0;
                end
            end
        end

        // R4: a status bit only rises after low samples
        p_rise_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_status[g]) |-> (!$past(sync_lvl[g]) && !$past(sync_lvl[g], 2)));

        // R5: a status bit only falls after high samples
        p_fall_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_status[g]) |-> ($past(sync_lvl[g]) && $past(sync_lvl[g], 2)));

        // R6: a held low is accepted within its window
        p_assert_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            lo_run <= LO_LIM);

        // R7: a held high releases within its window
        p_release_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hi_run <= HI_LIM);
    end

endmodule

bind irqc_combiner irqc_checker #(
    .N_CH      (N_CH),
    .LOW_HOLD  (LOW_HOLD),
    .HIGH_HOLD (HIGH_HOLD)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_lvl      (sync_lvl),
    .irq_status    (irq_status),
    .irq_drive_low (irq_drive_low)
);

// File: tb/irqc_combiner_tb.sv
`timescale 1ns/1ps
module irqc_combiner_tb;

    localparam int NC   = 4;
    localparam int SYN  = 2;
    localparam int LO_N = 200;
    localparam int HI_N = 100;
    localparam int MAX_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] irq_in_n = '1;
    logic [NC-1:0] irq_status;
    logic          irq_drive_low;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // bench model state
    logic [NC-1:0] hist [SYN+1];
    logic [NC-1:0] exp_st = '0;
    int            run [NC];

    always #2.5 clk = ~clk;

    irqc_combiner #(
        .N_CH        (NC),
        .SYNC_STAGES (SYN),
        .LOW_HOLD    (LO_N),
        .HIGH_HOLD   (HI_N)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_in_n      (irq_in_n),
        .irq_status    (irq_status),
        .irq_drive_low (irq_drive_low)
    );

    task automatic chk(input string tag, input logic [NC-1:0] got, input logic [NC-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Requirement model: a channel's accepted level flips after the opposite
    // level has been seen for LO_N (to pending) or HI_N (to idle) samples.
    function automatic void model_step(input logic [NC-1:0] raw);
        for (int i = 0; i < NC; i++) begin
            if (raw[i] == exp_st[i]) begin      // raw low (0) differs from idle (0)? map below
                run[i]++;
                if (!exp_st[i] && run[i] >= LO_N) begin
                    exp_st[i] = 1'b1;
                    run[i]    = 0;
                end else if (exp_st[i] && run[i] >= HI_N) begin
                    exp_st[i] = 1'b0;
                    run[i]    = 0;
                end
            end else begin
                run[i] = 0;
            end
        end
    endfunction

    // One cycle: at the falling edge, advance the model with the value the
    // filter saw at the last rising edge, compare, then apply the next input.
    task automatic tick(input logic [NC-1:0] nxt, input string tag);
        @(negedge clk);
        for (int s = SYN; s > 0; s--) hist[s] = hist[s-1];
        hist[0] = irq_in_n;
        model_step(hist[SYN]);
        chk(tag, irq_status, exp_st);
        chk("R2", {{(NC-1){1'b0}}, irq_drive_low}, {{(NC-1){1'b0}}, (exp_st != '0)});
        irq_in_n = nxt;
    endtask

    task automatic hold(input logic [NC-1:0] v, input int n, input string tag);
        for (int k = 0; k < n; k++) tick(v, tag);
    endtask

    initial begin
        for (int s = 0; s <= SYN; s++) hist[s] = '1;
        for (int i = 0; i < NC; i++) run[i] = 0;
    end

    // watchdog
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] cur;
        int            left [NC];
        void'($urandom(32'd4711));

        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", irq_status, '0);
        chk("R1", {{(NC-1){1'b0}}, irq_drive_low}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        hold('1, 5, "R1");
        chk("R1", irq_status, '0);

        // R6: exact assert latency on channel 0
        tick(4'b1110, "R6");
        hold(4'b1110, LO_N + SYN - 1, "R6");
        chk("R6", irq_status, 4'b0000);
        hold(4'b1110, 1, "R6");
        chk("R6", irq_status, 4'b0001);
        chk("R2", {3'b000, irq_drive_low}, 4'b0001);

        // R5: high pulse of HI_N-1 cycles is ignored while pending
        tick(4'b1111, "R5");
        hold(4'b1111, HI_N - 2, "R5");
        tick(4'b1110, "R5");
        hold(4'b1110, 2 * HI_N, "R5");
        chk("R5", irq_status, 4'b0001);

        // R7 / R8: exact release latency, clears without further action
        tick(4'b1111, "R7");
        hold(4'b1111, HI_N + SYN - 1, "R7");
        chk("R7", irq_status, 4'b0001);
        hold(4'b1111, 1, "R8");
        chk("R8", irq_status, 4'b0000);
        chk("R8", {3'b000, irq_drive_low}, 4'b0000);

        // R4: low of LO_N-1 cycles rejected on channel 2
        tick(4'b1011, "R4");
        hold(4'b1011, LO_N - 2, "R4");
        tick(4'b1111, "R4");
        hold(4'b1111, LO_N + 10, "R4");
        chk("R4", irq_status, 4'b0000);
        // R4: low of exactly LO_N cycles accepted
        tick(4'b1011, "R4");
        hold(4'b1011, LO_N - 1, "R4");
        tick(4'b1111, "R4");
        hold(4'b1111, SYN + 1, "R4");
        chk("R4", irq_status, 4'b0100);
        hold(4'b1111, HI_N + 10, "R8");
        chk("R8", irq_status, 4'b0000);

        // R3: bit mapping with two channels, then release one of them
        tick(4'b0101, "R3");
        hold(4'b0101, LO_N + SYN, "R3");
        chk("R3", irq_status, 4'b1010);
        chk("R2", {3'b000, irq_drive_low}, 4'b0001);
        tick(4'b0111, "R9");
        hold(4'b0111, HI_N + SYN, "R9");
        chk("R9", irq_status, 4'b1000);
        tick(4'b1111, "R8");
        hold(4'b1111, HI_N + SYN + 2, "R8");
        chk("R8", irq_status, 4'b0000);

        // R9: independent random pulse trains around both windows
        cur = '1;
        for (int i = 0; i < NC; i++) left[i] = $urandom_range(1, 2 * LO_N);
        for (int c = 0; c < 40000; c++) begin
            for (int i = 0; i < NC; i++) begin
                left[i]--;
                if (left[i] <= 0) begin
                    cur[i]  = ~cur[i];
                    left[i] = (($urandom & 3) == 0) ? $urandom_range(1, 8)
                            : $urandom_range(HI_N - 20, LO_N + 40);
                end
            end
            tick(cur, "R9");
        end
        hold('1, LO_N + HI_N, "R9");
        chk("R9", irq_status, 4'b0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule